// File: doc/BRIEF.md
# Bit-serial permutation round engine

This block performs one round of a 320-bit sponge permutation with very little logic. It touches one bit of each state row per clock. The state is held as five 64-bit rows, x0 to x4. Each row is a shift register with its own shift enable. A sixth 64-bit shift register holds a partly built linear-layer result.

A round runs as eight windows of 64 cycles each, for 512 cycles in total:

- One window injects an optional 64-bit operand, such as a key or data word, into a chosen set of rows.
- One window pushes every bit slice through a single shared 5-bit S-box. The 8-bit round constant is folded into row x2 on the way.
- Six windows compute the per-row diffusion. The temporary register builds one row's result while it writes the previous row's result back.

Software or a mode controller outside the block loads the state in parallel, starts a round and reads the state back once the done pulse arrives.

Top module: `asc_ser_round`

## Requirements
- R1: After a synchronous reset, busy and done are 0 and all 320 state bits are 0.
- R2: While busy is 0, ld copies ld_state into the state on the next clock edge. Bits [64*i+63 : 64*i] hold row x_i. While busy is 1, ld has no effect on the result.
- R3: When start is sampled with busy at 0, busy is 1 for exactly 512 clock cycles. Done is then 1 for a single cycle, in the cycle in which busy returns to 0.
- R4: A start sampled while busy is 1 is ignored. It neither lengthens the round nor begins a second one.
- R5: The inj_data, inj_mask and rc inputs are captured when a round starts. inj_data is XORed into every row x_i whose inj_mask bit i is 1. Rows whose mask bit is 0 keep their value through this step.
- R6: After the injection, rc is XORed into bits 7..0 of x2.
- R7: Next, each bit position j goes through the 5-bit substitution, using the bits of x0 to x4 at position j. The substitution is these steps in order: x0^=x4, x4^=x3, x2^=x1; then each xi ^= (~x(i+1)) & x(i+2), with indices mod 5 and all five using the values from before this step; then x1^=x0, x0^=x4, x3^=x2, and x2 is inverted.
- R8: Finally, each row becomes x ^ (x rotated right by a) ^ (x rotated right by b). The (a,b) pairs are x0:(19,28), x1:(61,39), x2:(1,6), x3:(10,17), x4:(7,41).
- R9: While idle, with no ld and no accepted start, the state holds its value. The result of a round stays on state after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one round when idle |
| rc | input | 8 | Round constant for x2 |
| inj_data | input | 64 | Operand injected into selected rows |
| inj_mask | input | 5 | Bit i selects row x_i for injection |
| ld | input | 1 | Parallel state load when idle |
| ld_state | input | 320 | State to load, x0 in the low 64 bits |
| state | output | 320 | Current state, x0 in the low 64 bits |
| busy | output | 1 | Round in progress |
| done | output | 1 | One-cycle pulse at round completion |

## Verification
The block is built with its fixed 64-bit row width, 8-bit constant and 512-cycle schedule.

The bench sweeps all 32 injection masks, so every combination of selected and unselected rows is covered. It also walks a single set bit through all 64 positions across the rows. This exposes every tap of the rotations, every slice of the S-box pass and the bit position at which each constant bit is applied.

Extra runs disturb a round with ld and start partway through. Each result is compared with a word-level round computed arithmetically in the bench.

// File: rtl/asc_ser_pkg.sv
package asc_ser_pkg;

    localparam int LANE_W = 64;
    localparam int ROWS   = 5;
    localparam int RC_W   = 8;
    localparam int WIN_N  = 8;
    localparam int CNT_W  = $clog2(WIN_N * LANE_W);
    localparam int BIT_W  = $clog2(LANE_W);
    localparam int ST_W   = ROWS * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [ROWS-1:0]   slice_t;

    typedef enum logic [2:0] {
        PH_INJ, PH_SUB, PH_L0, PH_L1, PH_L2, PH_L3, PH_L4, PH_L5
    } phase_e;

    // one 5-bit slice, bit i belongs to row x_i
    function automatic slice_t sbox5(input slice_t s);
        slice_t a;
        slice_t t;
        a = s;
        a[0] = a[0] ^ a[4];
        a[4] = a[4] ^ a[3];
        a[2] = a[2] ^ a[1];
        for (int i = 0; i < ROWS; i++)
            t[i] = ~a[(i + 1) % ROWS] & a[(i + 2) % ROWS];
        a = a ^ t;
        a[1] = a[1] ^ a[0];
        a[0] = a[0] ^ a[4];
        a[3] = a[3] ^ a[2];
        a[2] = ~a[2];
        return a;
    endfunction

    function automatic int rot_a(input int row);
        case (row)
            0: return 19;
            1: return 61;
            2: return 1;
            3: return 10;
            default: return 7;
        endcase
    endfunction

    function automatic int rot_b(input int row);
        case (row)
            0: return 28;
            1: return 39;
            2: return 6;
            3: return 17;
            default: return 41;
        endcase
    endfunction

endpackage

// File: rtl/asc_ser_ctrl.sv
module asc_ser_ctrl
    import asc_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output phase_e           phase,
    output logic [BIT_W-1:0] tick
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == '1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign phase = phase_e'(cnt[CNT_W-1 -: 3]);
    assign tick  = cnt[BIT_W-1:0];

endmodule

// File: rtl/asc_ser_lane.sv
module asc_ser_lane
    import asc_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  lane_t ld_val,
    input  logic  en,
    input  logic  din,
    output lane_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else if (en)
            q <= {q[LANE_W-2:0], din};
    end

endmodule

// File: rtl/asc_ser_sigma.sv
module asc_ser_sigma
    import asc_ser_pkg::*;
#(
    parameter int ROW = 0
) (
    input  lane_t row_q,
    output logic  bit_o
);

    // after t left rotations the bit j = 63-t sits at the top;
    // its partner at j+r sits at position r-1
    localparam int TAP_A = rot_a(ROW) - 1;
    localparam int TAP_B = rot_b(ROW) - 1;

    assign bit_o = row_q[LANE_W-1] ^ row_q[TAP_A] ^ row_q[TAP_B];

endmodule

// File: rtl/asc_ser_round.sv
module asc_ser_round
    import asc_ser_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [7:0]   rc,
    input  logic [63:0]  inj_data,
    input  logic [4:0]   inj_mask,
    input  logic         ld,
    input  logic [319:0] ld_state,
    output logic [319:0] state,
    output logic         busy,
    output logic         done
);

    phase_e           phase;
    logic [BIT_W-1:0] tick;
    lane_t            x [ROWS];
    lane_t            tmp_q;
    lane_t            op_q;
    lane_t            rc_ext;
    logic [RC_W-1:0]  rc_q;
    slice_t           mask_q;
    slice_t           msb, en, din, sig, sb_in, sb_out;
    logic             tmp_en, tmp_din, cbit, ld_ok, go;
    logic [2:0]       comp, wb;

    asc_ser_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .phase(phase), .tick(tick)
    );

    assign ld_ok = ld & ~busy;
    assign go    = start & ~busy;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        asc_ser_lane u_lane (
            .clk(clk), .rst(rst), .ld(ld_ok),
            .ld_val(ld_state[r*LANE_W +: LANE_W]),
            .en(en[r]), .din(din[r]), .q(x[r])
        );
        asc_ser_sigma #(.ROW(r)) u_sig (.row_q(x[r]), .bit_o(sig[r]));
        assign msb[r] = x[r][LANE_W-1];
        assign state[r*LANE_W +: LANE_W] = x[r];
    end

    asc_ser_lane u_tmp (
        .clk(clk), .rst(rst), .ld(1'b0), .ld_val('0),
        .en(tmp_en), .din(tmp_din), .q(tmp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            rc_q   <= '0;
            mask_q <= '0;
        end else if (go) begin
            op_q   <= inj_data;
            rc_q   <= rc;
            mask_q <= inj_mask;
        end else if (busy && phase == PH_INJ) begin
            op_q <= op_q << 1;
        end
    end

    // slice index passing the S-box is 63 - tick
    assign rc_ext = lane_t'(rc_q);
    assign cbit   = rc_ext[~tick];
    assign sb_in  = {msb[4], msb[3], msb[2] ^ cbit, msb[1], msb[0]};
    assign sb_out = sbox5(sb_in);
    assign comp   = 3'(phase) - 3'd2;
    assign wb     = 3'(phase) - 3'd3;

    always_comb begin
        en      = '0;
        din     = '0;
        tmp_en  = 1'b0;
        tmp_din = 1'b0;
        if (busy) begin
            case (phase)
                PH_INJ: begin
                    for (int r = 0; r < ROWS; r++) begin
                        en[r]  = mask_q[r];
                        din[r] = msb[r] ^ op_q[LANE_W-1];
                    end
                end
                PH_SUB: begin
                    en  = '1;
                    din = sb_out;
                end
                default: begin
                    tmp_en = 1'b1;
                    if (phase != PH_L5) begin
                        en[comp]  = 1'b1;
                        din[comp] = msb[comp];
                        tmp_din   = sig[comp];
                    end
                    if (phase != PH_L0) begin
                        en[wb]  = 1'b1;
                        din[wb] = tmp_q[LANE_W-1];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/asc_ser_chk.sv
module asc_ser_chk
    import asc_ser_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          ld,
    input logic          busy,
    input logic          done,
    input logic [ST_W-1:0] state
);

    logic [CNT_W:0] busy_cyc;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cyc <= '0;
        else if (start && !busy)
            busy_cyc <= '0;
        else if (busy)
            busy_cyc <= busy_cyc + 1'b1;
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R3
    round_len_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cyc == (CNT_W+1)'(WIN_N * LANE_W)));

    // R3
    start_go_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !ld) |=> $stable(state));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (state == '0 && !busy && !done));

endmodule

bind asc_ser_round asc_ser_chk i_chk (
    .clk(clk), .rst(rst), .start(start), .ld(ld),
    .busy(busy), .done(done), .state(state)
);

// File: tb/test_asc_ser_round.sv
module test_asc_ser_round;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [7:0]   rc;
    logic [63:0]  inj_data;
    logic [4:0]   inj_mask;
    logic         ld;
    logic [319:0] ld_state;
    logic [319:0] state;
    logic         busy;
    logic         done;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    asc_ser_round i_asc_ser_round (
        .clk(clk), .rst(rst), .start(start), .rc(rc), .inj_data(inj_data),
        .inj_mask(inj_mask), .ld(ld), .ld_state(ld_state),
        .state(state), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] ror(input logic [63:0] v, input int r);
        return (v >> r) | (v << (64 - r));
    endfunction

    function automatic logic [319:0] ref_round(input logic [319:0] s, input logic [63:0] d,
                                               input logic [4:0] m, input logic [7:0] c);
        logic [63:0] w [5];
        logic [63:0] t [5];
        logic [319:0] o;
        for (int i = 0; i < 5; i++) begin
            w[i] = s[64*i +: 64];
            if (m[i]) w[i] = w[i] ^ d;
        end
        w[2] = w[2] ^ {56'd0, c};
        w[0] = w[0] ^ w[4];
        w[4] = w[4] ^ w[3];
        w[2] = w[2] ^ w[1];
        for (int i = 0; i < 5; i++) t[i] = ~w[(i + 1) % 5] & w[(i + 2) % 5];
        for (int i = 0; i < 5; i++) w[i] = w[i] ^ t[i];
        w[1] = w[1] ^ w[0];
        w[0] = w[0] ^ w[4];
        w[3] = w[3] ^ w[2];
        w[2] = ~w[2];
        o[63:0]    = w[0] ^ ror(w[0], 19) ^ ror(w[0], 28);
        o[127:64]  = w[1] ^ ror(w[1], 61) ^ ror(w[1], 39);
        o[191:128] = w[2] ^ ror(w[2], 1)  ^ ror(w[2], 6);
        o[255:192] = w[3] ^ ror(w[3], 10) ^ ror(w[3], 17);
        o[319:256] = w[4] ^ ror(w[4], 7)  ^ ror(w[4], 41);
        return o;
    endfunction

    function automatic logic [63:0] mix(input int k);
        return (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ (64'hD1B54A32D192ED03 >> (k % 29));
    endfunction

    task automatic check(input bit ok, input string req, input logic [319:0] act,
                         input logic [319:0] exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // disturb: pulse ld with junk and start partway through (R2, R4)
    task automatic run(input logic [319:0] s, input logic [63:0] d, input logic [4:0] m,
                       input logic [7:0] c, input bit disturb);
        logic [319:0] exp;
        int n;
        exp = ref_round(s, d, m, c);
        @(negedge clk);
        ld = 1'b1; ld_state = s;
        @(negedge clk);
        ld = 1'b0;
        check(state == s, "R2 load", state, s);
        start = 1'b1; inj_data = d; inj_mask = m; rc = c;
        @(negedge clk);
        start = 1'b0; inj_data = ~d; inj_mask = ~m; rc = ~c;
        n = 1;
        while (!done && n < 2000) begin
            if (disturb && n == 200) begin
                ld = 1'b1; ld_state = ~s; start = 1'b1;
            end else begin
                ld = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            n = n + 1;
        end
        ld = 1'b0; start = 1'b0;
        check(n == 513, "R3 round length", 320'(n), 320'd513);
        check(state == exp, disturb ? "R2/R4 round with ld and start while busy"
                                    : "R5-R8 round result", state, exp);
        check(!busy, "R3 busy low at done", 320'(busy), 320'd0);
        @(negedge clk);
        check(!done, "R3 done single cycle", 320'(done), 320'd0);
        repeat (3) @(negedge clk);
        check(!busy && state == exp, "R9/R4 idle hold after done", state, exp);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; rc = '0; inj_data = '0; inj_mask = '0;
        ld = 1'b0; ld_state = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(state == '0 && !busy && !done, "R1 reset state", state, 320'd0);

        // R5: every injection mask
        for (int m = 0; m < 32; m++)
            run({mix(5*m), mix(5*m+1), mix(5*m+2), mix(5*m+3), mix(5*m+4)},
                mix(m + 100), 5'(m), 8'(m * 37 + 11), 1'b0);

        // R6/R7/R8: single set bit walked over all positions and rows
        for (int b = 0; b < 64; b++) begin
            logic [319:0] s;
            s = '0;
            s[64*(b % 5) + b] = 1'b1;
            run(s, 64'd0, 5'd0, 8'(1 << (b % 8)), 1'b0);
        end

        // R6: all constant bits, zero state
        run('0, 64'd0, 5'd0, 8'hFF, 1'b0);
        run('1, 64'hFFFF_0000_FFFF_0000, 5'b10101, 8'h4B, 1'b0);

        // R2/R4: disturbance during a run
        run({mix(7), mix(8), mix(9), mix(10), mix(11)}, mix(12), 5'b01101, 8'h96, 1'b1);
        run({mix(20), mix(21), mix(22), mix(23), mix(24)}, mix(25), 5'b11111, 8'h3C, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule